// File: doc/BRIEF.md
# RAM Chip-Enable Write-Protect Gate

This block sits in the active-low chip-enable path between a processor and a static RAM. It protects the RAM during supply faults. While the supply supervisor reports a healthy rail, every chip-enable edge from the processor reaches the RAM after a fixed number of clocks. When the supervisor raises its reset, the gate shuts and holds the RAM's chip-enable inactive (high). Only then can a processor that is losing power not corrupt stored data.

A write may be in flight at the moment reset arrives, seen as chip-enable low. In that case the gate stays open for a bounded grace window so the access can complete. The window ends at the first release of chip-enable or when the window count runs out, whichever comes first. After the gate shuts it stays shut and ignores any further chip-enable pulses. It opens again only once the supervisor has dropped its reset and the processor drives chip-enable low.

Top module: `ram_ce_guard`

## Requirements
- R1: While the logic reset `rst_n` is low, and after its release until the gate is opened, `ram_ce_n` is high (inactive) whatever `cpu_ce_n` does.
- R2: While the gate is open and `sup_rst` is low, `ram_ce_n` equals `cpu_ce_n` delayed by exactly SYNC_STAGES+1 rising clock edges (3 with defaults).
- R3: If `sup_rst` is sampled high while the synchronized chip-enable is high, the gate shuts on that same edge. `ram_ce_n` stays high with no grace window.
- R4: If `sup_rst` is sampled high while the synchronized chip-enable is low, `ram_ce_n` stays low through the next GRACE_CYCLES-1 edges. It goes high on edge GRACE_CYCLES counted after the sampling edge, provided chip-enable is held low.
- R5: A rise of `cpu_ce_n` during the grace window shuts the gate. `ram_ce_n` goes high after the normal R2 latency, before the window ends.
- R6: Once the gate is shut, a low level or pulse on `cpu_ce_n` leaves `ram_ce_n` high for as long as `sup_rst` stays high.
- R7: A shut gate reopens on the edge where `sup_rst` is low and the synchronized chip-enable is low. On that edge `ram_ce_n` goes low. While `sup_rst` is low and chip-enable stays high, the output stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Gate clock |
| rst_n | input | 1 | Asynchronous active-low logic reset, released synchronously inside |
| sup_rst | input | 1 | Supervisor reset, active high, synchronous to `clk` |
| cpu_ce_n | input | 1 | Processor chip-enable, active low, asynchronous |
| ram_ce_n | output | 1 | Gated chip-enable to the RAM, active low, registered |

## Verification
The checker assumes that `sup_rst` already belongs to the `clk` domain, so the state machine uses it without synchronization. It also assumes that `cpu_ce_n` holds each level for at least a few clocks, long enough to cross the synchronizer. The bench changes both inputs only on falling clock edges. It holds each level for at least several cycles and never toggles chip-enable faster than the synchronizer depth. Grace-window checks hold chip-enable steady for longer than GRACE_CYCLES before they raise the supervisor reset.

// File: rtl/ceg_pkg.sv
package ceg_pkg;

  typedef enum logic [1:0] {
    GATE_SHUT  = 2'd0,
    GATE_OPEN  = 2'd1,
    GATE_GRACE = 2'd2
  } gate_state_e;

endpackage

// File: rtl/ceg_reset_sync.sv
module ceg_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/ceg_sync_chain.sv
module ceg_sync_chain #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] flop_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) flop_q[0] <= RESET_VAL;
          else        flop_q[0] <= d_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) flop_q[i] <= RESET_VAL;
          else        flop_q[i] <= flop_q[i-1];
        end
      end
    end
  endgenerate

  assign q_sync = flop_q[STAGES-1];

endmodule

// File: rtl/ceg_grace_timer.sv
module ceg_grace_timer #(
  parameter int GRACE_CYCLES = 18,
  localparam int CNT_W = $clog2(GRACE_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  output logic             expire,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(GRACE_CYCLES);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = LOAD_VAL;
    end else if (run && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = run && (cnt_q == ONE);
  assign count  = cnt_q;

endmodule

// File: rtl/ceg_gate_fsm.sv
module ceg_gate_fsm
  import ceg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sup_rst,
  input  logic        ce_sync_n,
  input  logic        grace_expire,
  output logic        grace_load,
  output logic        grace_run,
  output gate_state_e state,
  output logic        ce_out_n
);

  gate_state_e state_q, state_d;
  logic        out_q, out_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_SHUT: begin
        if (!sup_rst && !ce_sync_n) state_d = GATE_OPEN;
      end
      GATE_OPEN: begin
        if (sup_rst) state_d = ce_sync_n ? GATE_SHUT : GATE_GRACE;
      end
      GATE_GRACE: begin
        if (ce_sync_n || grace_expire) state_d = GATE_SHUT;
      end
      default: state_d = GATE_SHUT;
    endcase
  end

  always_comb begin
    out_d = (state_d == GATE_SHUT) ? 1'b1 : ce_sync_n;
  end

  assign grace_load = (state_q == GATE_OPEN) && sup_rst && !ce_sync_n;
  assign grace_run  = (state_q == GATE_GRACE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_SHUT;
      out_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      out_q   <= out_d;
    end
  end

  assign state    = state_q;
  assign ce_out_n = out_q;

endmodule

// File: rtl/ram_ce_guard.sv
module ram_ce_guard
  import ceg_pkg::*;
#(
  parameter int GRACE_CYCLES = 18,
  parameter int SYNC_STAGES  = 2,
  parameter int RST_STAGES   = 2,
  localparam int CNT_W = $clog2(GRACE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_rst,
  input  logic cpu_ce_n,
  output logic ram_ce_n
);

  logic             rst_int_n;
  logic             ce_sync_n;
  logic             grace_load;
  logic             grace_run;
  logic             grace_expire;
  logic [CNT_W-1:0] grace_count;
  gate_state_e      gate_state;

  ceg_reset_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ceg_sync_chain #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_ce_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .d_async (cpu_ce_n),
    .q_sync  (ce_sync_n)
  );

  ceg_grace_timer #(.GRACE_CYCLES(GRACE_CYCLES)) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load   (grace_load),
    .run    (grace_run),
    .expire (grace_expire),
    .count  (grace_count)
  );

  ceg_gate_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .sup_rst      (sup_rst),
    .ce_sync_n    (ce_sync_n),
    .grace_expire (grace_expire),
    .grace_load   (grace_load),
    .grace_run    (grace_run),
    .state        (gate_state),
    .ce_out_n     (ram_ce_n)
  );

endmodule

// File: rtl/ceg_checker.sv
module ceg_checker
  import ceg_pkg::*;
#(
  parameter int GRACE_CYCLES = 18,
  localparam int CNT_W = $clog2(GRACE_CYCLES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sup_rst,
  input logic             ce_sync_n,
  input logic             ram_ce_n,
  input gate_state_e      gate_state,
  input logic [CNT_W-1:0] grace_count
);

  localparam logic [CNT_W-1:0] CMAX = CNT_W'(GRACE_CYCLES);

  // R1, R6: a shut gate never drives the RAM enable active
  p_shut_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_state == GATE_SHUT) |-> ram_ce_n);

  // R3: reset seen with chip-enable high shuts at once
  p_shut_direct_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_state == GATE_OPEN && sup_rst && ce_sync_n) |=> (gate_state == GATE_SHUT && ram_ce_n));

  // R4: grace entered only from an open gate under reset with chip-enable low
  p_grace_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gate_state) == GATE_OPEN && gate_state == GATE_GRACE) |-> ($past(sup_rst) && !$past(ce_sync_n)));

  // R4: window count stays within its bound
  p_grace_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_state == GATE_GRACE) |-> (grace_count != '0 && grace_count <= CMAX));

  // R5: release during grace closes the gate on the next edge
  p_release_closes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_state == GATE_GRACE && ce_sync_n) |=> (gate_state == GATE_SHUT));

  // R7: reopening needs reset low and chip-enable low
  p_reopen_cond_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gate_state) == GATE_SHUT && gate_state == GATE_OPEN) |-> (!$past(sup_rst) && !$past(ce_sync_n) && !ram_ce_n));

endmodule

bind ram_ce_guard ceg_checker #(.GRACE_CYCLES(GRACE_CYCLES)) u_ceg_checker (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .sup_rst     (sup_rst),
  .ce_sync_n   (ce_sync_n),
  .ram_ce_n    (ram_ce_n),
  .gate_state  (gate_state),
  .grace_count (grace_count)
);

// File: tb/ram_ce_guard_test.sv
module ram_ce_guard_test;

  localparam int CLK_PERIOD = 10;
  localparam int GRACE      = 18;
  localparam int LAT        = 3;   // SYNC_STAGES + 1

  logic clk;
  logic rst_n;
  logic sup_rst;
  logic cpu_ce_n;
  logic ram_ce_n;

  int checks;
  int failures;
  bit done;

  ram_ce_guard #(.GRACE_CYCLES(GRACE), .SYNC_STAGES(2)) uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sup_rst  (sup_rst),
    .cpu_ce_n (cpu_ce_n),
    .ram_ce_n (ram_ce_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s ram_ce_n actual=%b expected=%b at %0t", req, actual, expected, $time);
    end
  endtask

  // R1: logic reset holds output inactive
  task automatic t_reset;
    rst_n = 1'b0; sup_rst = 1'b1; cpu_ce_n = 1'b0;
    tick(3);
    check("R1 during reset", ram_ce_n, 1'b1);
    rst_n = 1'b1;
    tick(6);
    check("R1 after release", ram_ce_n, 1'b1);
  endtask

  // R6/R7: power-up activity ignored, reopen on reset low and ce low
  task automatic t_powerup;
    for (int i = 0; i < 4; i++) begin
      cpu_ce_n = ~cpu_ce_n;
      tick(4);
      check("R6 power-up ce ignored", ram_ce_n, 1'b1);
    end
    cpu_ce_n = 1'b1;
    tick(5);
    sup_rst = 1'b0;
    tick(5);
    check("R7 reset low ce high stays high", ram_ce_n, 1'b1);
    cpu_ce_n = 1'b0;
    tick(LAT - 1);
    check("R7 before reopen latency", ram_ce_n, 1'b1);
    tick(1);
    check("R7 reopened", ram_ce_n, 1'b0);
  endtask

  // R2: pass-through with fixed latency
  task automatic t_follow;
    cpu_ce_n = 1'b1;
    tick(LAT - 1);
    check("R2 rise not yet", ram_ce_n, 1'b0);
    tick(1);
    check("R2 rise passed", ram_ce_n, 1'b1);
    cpu_ce_n = 1'b0;
    tick(LAT - 1);
    check("R2 fall not yet", ram_ce_n, 1'b1);
    tick(1);
    check("R2 fall passed", ram_ce_n, 1'b0);
    cpu_ce_n = 1'b1;
    tick(4);
    cpu_ce_n = 1'b0;
    tick(4);
    check("R2 short low pulse", ram_ce_n, 1'b0);
    cpu_ce_n = 1'b1;
    tick(5);
    check("R2 idle high", ram_ce_n, 1'b1);
  endtask

  // R3: reset with ce high shuts immediately, then R6 ignores pulses
  task automatic t_shut_direct;
    sup_rst = 1'b1;
    tick(1);
    check("R3 shut at once", ram_ce_n, 1'b1);
    cpu_ce_n = 1'b0;
    tick(GRACE + 5);
    check("R6 ce low under reset", ram_ce_n, 1'b1);
    sup_rst = 1'b0;
    tick(1);
    check("R7 reopen with ce already low", ram_ce_n, 1'b0);
  endtask

  // R4: grace window runs to its full length
  task automatic t_grace_full;
    tick(GRACE + 2);
    sup_rst = 1'b1;
    tick(GRACE);
    check("R4 still low at window end-1", ram_ce_n, 1'b0);
    tick(1);
    check("R4 high at window end", ram_ce_n, 1'b1);
    tick(10);
    check("R6 stays shut after window", ram_ce_n, 1'b1);
    cpu_ce_n = 1'b1;
    tick(5);
    sup_rst = 1'b0;
    cpu_ce_n = 1'b0;
    tick(LAT + 1);
    check("R7 reopen after window", ram_ce_n, 1'b0);
  endtask

  // R5: early release closes the gate, later pulses ignored
  task automatic t_grace_early;
    tick(GRACE + 2);
    sup_rst = 1'b1;
    tick(2);
    cpu_ce_n = 1'b1;
    tick(LAT - 1);
    check("R5 before release seen", ram_ce_n, 1'b0);
    tick(1);
    check("R5 release closes", ram_ce_n, 1'b1);
    cpu_ce_n = 1'b0;
    tick(GRACE + 4);
    check("R6 ce low after early close", ram_ce_n, 1'b1);
    cpu_ce_n = 1'b1;
    tick(4);
    cpu_ce_n = 1'b0;
    tick(4);
    check("R6 pulse after early close", ram_ce_n, 1'b1);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    t_reset();
    t_powerup();
    t_follow();
    t_shut_direct();
    t_grace_full();
    t_grace_early();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule